// File: doc/BRIEF.md
# Block Accelerator Command Sequencer

This block is the control front end of an accelerator that works on whole data blocks. A host pushes 16-bit command words into a small queue. The sequencer takes one command at a time from the queue and carries it out. A command can do one of four things:

- stall until an inbound block transfer into one of the buffer banks has been reported complete,
- hold the compute-busy line high for a programmed number of cycles, standing in for the datapath,
- pulse one of several completion sync lines toward a DMA channel,
- do nothing.

Commands run strictly in order, so every sync pulse follows all the work queued ahead of it. A typical program is wait-for-input, compute, send-sync. The data buffer is split into two banks. The buffer ports are independent of the sequencer, so a DMA engine can fill one bank while the compute runs on the other. A transfer that completes before its wait command reaches the head of the queue is remembered, one completion per bank.

Top module: `blkacc_cmd_seq`

## Requirements
- R1: After reset, idle is 1, busy is 0, sync_out is all zero, cmd_full is 0 and overflow is 0.
- R2: Command words have the fields op = bits [15:14], sel = bits [13:12] and count = bits [11:0]. Commands are carried out one at a time in the order they were written, and each starts only after the one before it has finished.
- R3: The queue holds QDEPTH (default 4) commands, and cmd_full is 1 while it holds that many. A write while the queue is full is dropped and sets overflow. Once set, overflow stays 1 until reset.
- R4: op 1 (wait-input) stalls the queue until an in_done pulse has arrived for bank sel[0]. A pulse that arrives before the command executes is remembered for that bank. Each wait-input command consumes one remembered pulse, so a second wait-input on the same bank stalls again.
- R5: op 2 (compute) holds busy high for exactly count consecutive cycles, with comp_bank equal to sel[0] for the whole run. A count of 0 produces no busy cycle.
- R6: op 3 (send-sync) raises sync_out[sel] for exactly one cycle, and at most one sync line is high in any cycle.
- R7: op 0 (no-op) produces no busy cycle and no sync pulse.
- R8: idle is 1 exactly when the queue is empty and no command is stalled or computing.
- R9: The buffer has NBANK banks, selected by bank, each with 2**BUF_AW words at address addr. A word written by buf_wr_en is returned on buf_rd_data one cycle after a buf_rd_en to the same bank and address. Banks are separate, and access works while a compute is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command write strobe |
| cmd_data | input | 16 | Command word |
| cmd_full | output | 1 | Queue full |
| overflow | output | 1 | Sticky flag: a write was dropped |
| in_done | input | 1 | Inbound block transfer complete pulse |
| in_bank | input | 1 | Bank that the completion belongs to |
| buf_wr_en | input | 1 | Buffer write strobe |
| buf_wr_bank | input | 1 | Buffer write bank |
| buf_wr_addr | input | 6 | Buffer write address |
| buf_wr_data | input | 16 | Buffer write data |
| buf_rd_en | input | 1 | Buffer read strobe |
| buf_rd_bank | input | 1 | Buffer read bank |
| buf_rd_addr | input | 6 | Buffer read address |
| buf_rd_data | output | 16 | Registered read data |
| busy | output | 1 | Compute in progress |
| comp_bank | output | 1 | Bank of the running compute |
| sync_out | output | 4 | Completion sync pulses, one per channel |
| idle | output | 1 | Queue empty and nothing executing |

## Verification
The bench fills the queue behind a stalled wait-input and then writes one more command. A design that kept the extra write, or that cleared overflow afterwards, would emit an extra event or show the flag low. It reports an input completion before the matching wait-input is queued, then queues a second wait-input on the same bank. A design that lost early completions would hang, and one that never consumed them would run through the second wait without stalling. Random programs of compute, sync and no-op commands are compared event by event with an expected trace. This catches merged or miscounted busy runs, zero-length computes that still raise busy, wrong sync channels and reordered commands. Buffer traffic during a long compute exposes bank aliasing and a stalled buffer.

// File: rtl/blkacc_pkg.sv
package blkacc_pkg;
  localparam int OP_W  = 2;
  localparam int SEL_W = 2;
  localparam int CNT_W = 12;
  localparam int CMD_W = OP_W + SEL_W + CNT_W;

  typedef enum logic [OP_W-1:0] {
    OP_NOP     = 2'd0,
    OP_WAIT_IN = 2'd1,
    OP_COMPUTE = 2'd2,
    OP_SYNC    = 2'd3
  } op_e;

  typedef struct packed {
    op_e              op;
    logic [SEL_W-1:0] sel;
    logic [CNT_W-1:0] cnt;
  } cmd_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_COMP = 2'd2
  } seq_st_e;
endpackage

// File: rtl/blkacc_cmd_fifo.sv
module blkacc_cmd_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic         ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          accept;

  assign full   = (cnt == (AW+1)'(DEPTH));
  assign empty  = (cnt == '0);
  assign accept = wr_valid && !full;
  assign head   = mem[rp];

  always_ff @(posedge clk) begin
    if (accept) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (accept) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + AW'(1);
      if (pop)    rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + AW'(1);
      case ({accept, pop})
        2'b10:   cnt <= cnt + (AW+1)'(1);
        2'b01:   cnt <= cnt - (AW+1)'(1);
        default: cnt <= cnt;
      endcase
      if (wr_valid && full) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/blkacc_bank_buf.sv
module blkacc_bank_buf #(
  parameter int NBANK = 2,
  parameter int AW    = 6,
  parameter int DW    = 16
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [$clog2(NBANK)-1:0] wr_bank,
  input  logic [AW-1:0]            wr_addr,
  input  logic [DW-1:0]            wr_data,
  input  logic                     rd_en,
  input  logic [$clog2(NBANK)-1:0] rd_bank,
  input  logic [AW-1:0]            rd_addr,
  output logic [DW-1:0]            rd_data
);
  localparam int BW    = $clog2(NBANK);
  localparam int WORDS = 2 ** (BW + AW);

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[{wr_bank, wr_addr}] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[{rd_bank, rd_addr}];
  end
endmodule

// File: rtl/blkacc_seq_ctrl.sv
module blkacc_seq_ctrl
  import blkacc_pkg::*;
#(
  parameter int NBANK = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  cmd_t                     head,
  input  logic                     q_empty,
  output logic                     pop,
  input  logic                     in_done,
  input  logic [$clog2(NBANK)-1:0] in_bank,
  output logic                     busy,
  output logic [$clog2(NBANK)-1:0] comp_bank,
  output logic [2**SEL_W-1:0]      sync_out,
  output logic                     exec_idle
);
  localparam int BW    = $clog2(NBANK);
  localparam int NSYNC = 2 ** SEL_W;

  seq_st_e          st;
  logic [CNT_W-1:0] ctr;
  logic [BW-1:0]    cur_bank;
  logic [NSYNC-1:0] sync_q;
  logic [NBANK-1:0] done_flag;
  logic             consume;

  assign pop     = (st == ST_IDLE) && !q_empty;
  assign consume = (st == ST_WAIT) && done_flag[cur_bank];

  for (genvar b = 0; b < NBANK; b++) begin : g_flag
    logic flg;
    always_ff @(posedge clk) begin
      if (rst)
        flg <= 1'b0;
      else if (in_done && in_bank == BW'(b))
        flg <= 1'b1;
      else if (consume && cur_bank == BW'(b))
        flg <= 1'b0;
    end
    assign done_flag[b] = flg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      ctr      <= '0;
      cur_bank <= '0;
      sync_q   <= '0;
    end else begin
      sync_q <= '0;
      case (st)
        ST_IDLE: begin
          if (pop) begin
            cur_bank <= head.sel[BW-1:0];
            case (head.op)
              OP_WAIT_IN: st <= ST_WAIT;
              OP_COMPUTE: begin
                if (head.cnt != '0) begin
                  st  <= ST_COMP;
                  ctr <= head.cnt;
                end
              end
              OP_SYNC:    sync_q[head.sel] <= 1'b1;
              default:    ;
            endcase
          end
        end
        ST_WAIT: begin
          if (consume) st <= ST_IDLE;
        end
        ST_COMP: begin
          ctr <= ctr - CNT_W'(1);
          if (ctr == CNT_W'(1)) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st == ST_COMP);
  assign comp_bank = cur_bank;
  assign sync_out  = sync_q;
  assign exec_idle = (st == ST_IDLE);
endmodule

// File: rtl/blkacc_cmd_seq.sv
module blkacc_cmd_seq
  import blkacc_pkg::*;
#(
  parameter int QDEPTH = 4,
  parameter int NBANK  = 2,
  parameter int BUF_AW = 6,
  parameter int DW     = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cmd_valid,
  input  logic [CMD_W-1:0]         cmd_data,
  output logic                     cmd_full,
  output logic                     overflow,
  input  logic                     in_done,
  input  logic [$clog2(NBANK)-1:0] in_bank,
  input  logic                     buf_wr_en,
  input  logic [$clog2(NBANK)-1:0] buf_wr_bank,
  input  logic [BUF_AW-1:0]        buf_wr_addr,
  input  logic [DW-1:0]            buf_wr_data,
  input  logic                     buf_rd_en,
  input  logic [$clog2(NBANK)-1:0] buf_rd_bank,
  input  logic [BUF_AW-1:0]        buf_rd_addr,
  output logic [DW-1:0]            buf_rd_data,
  output logic                     busy,
  output logic [$clog2(NBANK)-1:0] comp_bank,
  output logic [2**SEL_W-1:0]      sync_out,
  output logic                     idle
);
  logic [CMD_W-1:0] head_w;
  logic             q_empty, pop, exec_idle;

  blkacc_cmd_fifo #(.DEPTH(QDEPTH), .W(CMD_W)) u_fifo (
    .clk(clk), .rst(rst), .wr_valid(cmd_valid), .wr_data(cmd_data),
    .pop(pop), .head(head_w), .empty(q_empty), .full(cmd_full), .ovf(overflow)
  );

  blkacc_seq_ctrl #(.NBANK(NBANK)) u_ctrl (
    .clk(clk), .rst(rst), .head(cmd_t'(head_w)), .q_empty(q_empty), .pop(pop),
    .in_done(in_done), .in_bank(in_bank), .busy(busy), .comp_bank(comp_bank),
    .sync_out(sync_out), .exec_idle(exec_idle)
  );

  blkacc_bank_buf #(.NBANK(NBANK), .AW(BUF_AW), .DW(DW)) u_buf (
    .clk(clk), .wr_en(buf_wr_en), .wr_bank(buf_wr_bank), .wr_addr(buf_wr_addr),
    .wr_data(buf_wr_data), .rd_en(buf_rd_en), .rd_bank(buf_rd_bank),
    .rd_addr(buf_rd_addr), .rd_data(buf_rd_data)
  );

  assign idle = q_empty && exec_idle;
endmodule

// File: rtl/blkacc_seq_chk.sv
module blkacc_seq_chk #(
  parameter int NSYNC = 4,
  parameter int BW    = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic             cmd_full,
  input logic             overflow,
  input logic             busy,
  input logic             idle,
  input logic [NSYNC-1:0] sync_out,
  input logic [BW-1:0]    comp_bank
);
  assert_sync_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sync_out));
  assert_no_overflow_clear_R3: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  assert_drop_sets_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_full) |=> overflow);
  assert_idle_not_busy_R8: assert property (@(posedge clk) disable iff (rst)
    idle |-> !busy);
  assert_full_not_idle_R8: assert property (@(posedge clk) disable iff (rst)
    cmd_full |-> !idle);
  assert_bank_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(comp_bank));
  assert_sync_after_work_R2: assert property (@(posedge clk) disable iff (rst)
    (|sync_out) |-> !busy);
endmodule

bind blkacc_cmd_seq blkacc_seq_chk #(.NSYNC(4), .BW($clog2(NBANK))) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_full(cmd_full),
  .overflow(overflow), .busy(busy), .idle(idle), .sync_out(sync_out),
  .comp_bank(comp_bank)
);

// File: tb/sim_blkacc_cmd_seq.sv
module sim_blkacc_cmd_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_data = '0;
  logic        cmd_full, overflow;
  logic        in_done = 1'b0;
  logic [0:0]  in_bank = '0;
  logic        buf_wr_en = 1'b0;
  logic [0:0]  buf_wr_bank = '0;
  logic [5:0]  buf_wr_addr = '0;
  logic [15:0] buf_wr_data = '0;
  logic        buf_rd_en = 1'b0;
  logic [0:0]  buf_rd_bank = '0;
  logic [5:0]  buf_rd_addr = '0;
  logic [15:0] buf_rd_data;
  logic        busy;
  logic [0:0]  comp_bank;
  logic [3:0]  sync_out;
  logic        idle;

  int checks = 0;
  int errors = 0;
  int ev [256];
  int ev_n = 0;
  int exp_ev [256];
  int exp_n = 0;
  int run_len = 0;
  int run_bank = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blkacc_cmd_seq u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .cmd_full(cmd_full), .overflow(overflow), .in_done(in_done), .in_bank(in_bank),
    .buf_wr_en(buf_wr_en), .buf_wr_bank(buf_wr_bank), .buf_wr_addr(buf_wr_addr),
    .buf_wr_data(buf_wr_data), .buf_rd_en(buf_rd_en), .buf_rd_bank(buf_rd_bank),
    .buf_rd_addr(buf_rd_addr), .buf_rd_data(buf_rd_data), .busy(busy),
    .comp_bank(comp_bank), .sync_out(sync_out), .idle(idle)
  );

  // event monitor: busy runs become 1000*bank+100+length, sync pulses their channel
  always @(negedge clk) begin
    if (!rst) begin
      if (busy) begin
        if (run_len == 0) run_bank = int'(comp_bank);
        run_len++;
      end else if (run_len != 0) begin
        if (ev_n < 256) ev[ev_n++] = 1000*run_bank + 100 + run_len;
        run_len = 0;
      end
      if (sync_out != 0) begin
        int idx = 99;
        if ($countones(sync_out) == 1)
          for (int i = 0; i < 4; i++) if (sync_out[i]) idx = i;
        if (ev_n < 256) ev[ev_n++] = idx;
      end
    end
  end

  function automatic int exp_event(int op, int sel, int cnt);
    if (op == 2 && cnt > 0) return 1000*(sel % 2) + 100 + cnt;
    if (op == 3) return sel;
    return -1;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic put_cmd(int op, int sel, int cnt);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = {op[1:0], sel[1:0], cnt[11:0]};
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic expect_cmd(int op, int sel, int cnt);
    int e = exp_event(op, sel, cnt);
    if (e >= 0) exp_ev[exp_n++] = e;
  endtask

  task automatic pulse_done(int bank);
    @(negedge clk);
    in_done = 1'b1;
    in_bank = bank[0:0];
    @(negedge clk);
    in_done = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (!idle && n < 5000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_log();
    ev_n = 0;
    exp_n = 0;
  endtask

  task automatic cmp_log(string req);
    check(ev_n == exp_n, req, ev_n, exp_n);
    for (int i = 0; i < exp_n && i < ev_n; i++)
      check(ev[i] == exp_ev[i], req, ev[i], exp_ev[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(idle == 1'b1, "R1 idle", idle, 1);
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(sync_out == 4'b0, "R1 sync", sync_out, 0);
    check(cmd_full == 1'b0, "R1 full", cmd_full, 0);
    check(overflow == 1'b0, "R1 overflow", overflow, 0);

    // R7 no-op, R5 zero-length compute
    clear_log();
    put_cmd(0, 3, 5);
    put_cmd(2, 1, 0);
    wait_idle();
    check(ev_n == 0, "R7 R5 no events", ev_n, 0);

    // R6 typical program, R5 compute length and bank
    clear_log();
    put_cmd(2, 1, 9);  expect_cmd(2, 1, 9);
    put_cmd(3, 2, 0);  expect_cmd(3, 2, 0);
    wait_idle();
    cmp_log("R5 R6 compute then sync");

    // R4 early completion is remembered
    clear_log();
    pulse_done(0);
    repeat (3) @(negedge clk);
    put_cmd(1, 0, 0);
    put_cmd(3, 1, 0);  expect_cmd(3, 1, 0);
    wait_idle();
    cmp_log("R4 early done");
    // R4 completion consumed: second wait stalls
    clear_log();
    put_cmd(1, 0, 0);
    put_cmd(3, 2, 0);
    repeat (20) @(negedge clk);
    check(ev_n == 0, "R4 stall", ev_n, 0);
    check(idle == 1'b0, "R8 not idle while stalled", idle, 0);
    pulse_done(0);
    expect_cmd(3, 2, 0);
    wait_idle();
    cmp_log("R4 release");
    check(idle == 1'b1, "R8 idle after drain", idle, 1);

    // R9 buffer access during a long compute on bank 1
    clear_log();
    put_cmd(2, 1, 60); expect_cmd(2, 1, 60);
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < 8; a++) begin
        @(negedge clk);
        buf_wr_en = 1'b1;
        buf_wr_bank = b[0:0];
        buf_wr_addr = a[5:0];
        buf_wr_data = 16'(b*16'h5000 + a*16'h0111 + 3);
      end
    @(negedge clk);
    buf_wr_en = 1'b0;
    check(busy == 1'b1, "R9 compute overlaps transfer", busy, 1);
    for (int a = 0; a < 8; a++) begin
      buf_rd_en = 1'b1;
      buf_rd_bank = 1'b0;
      buf_rd_addr = a[5:0];
      @(negedge clk);
      buf_rd_en = 1'b0;
      check(buf_rd_data == 16'(a*16'h0111 + 3), "R9 bank0 read",
            buf_rd_data, a*16'h0111 + 3);
    end
    buf_rd_en = 1'b1;
    buf_rd_bank = 1'b1;
    buf_rd_addr = 6'd5;
    @(negedge clk);
    buf_rd_en = 1'b0;
    check(buf_rd_data == 16'(16'h5000 + 5*16'h0111 + 3), "R9 bank1 read",
          buf_rd_data, 16'h5000 + 5*16'h0111 + 3);
    wait_idle();
    cmp_log("R9 R5 long compute");

    // R3 overflow behind a stalled wait on bank 1
    clear_log();
    put_cmd(1, 1, 0);
    repeat (3) @(negedge clk);
    for (int c = 0; c < 4; c++) begin
      put_cmd(3, c, 0);
      expect_cmd(3, c, 0);
    end
    check(cmd_full == 1'b1, "R3 full", cmd_full, 1);
    check(overflow == 1'b0, "R3 no overflow yet", overflow, 0);
    put_cmd(2, 0, 7);
    check(overflow == 1'b1, "R3 overflow set", overflow, 1);
    pulse_done(1);
    wait_idle();
    cmp_log("R3 R2 dropped write");
    check(overflow == 1'b1, "R3 overflow sticky", overflow, 1);

    // R2 random programs of compute, sync and no-op
    for (int r = 0; r < 8; r++) begin
      int len = 1 + int'($urandom_range(9));
      clear_log();
      for (int k = 0; k < len; k++) begin
        int op, sel, cnt;
        op  = int'($urandom_range(2));
        op  = (op == 1) ? 3 : op;
        sel = int'($urandom_range(3));
        cnt = int'($urandom_range(15));
        while (cmd_full) @(negedge clk);
        put_cmd(op, sel, cnt);
        expect_cmd(op, sel, cnt);
      end
      wait_idle();
      cmp_log("R2 random program");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule